// File: doc/BRIEF.md
# Aperture Remapping Translation Table

This block translates device addresses that fall inside a fixed window (the aperture) into physical addresses, one 4 KiB page at a time. It holds one table entry per page of the aperture. Each entry carries a valid flag and a physical page number. A client presents a device address on the lookup port. In the same cycle it receives either the translated physical address or a fault flag.

Software never addresses the table directly. It writes a full device byte address into an entry-address register. It then writes or reads an entry-data register, which reaches the entry covering that address. A one-bit enable in a configuration register switches translation on and off. Stepping the entry address in 4 KiB increments walks the whole table, which lets software save or restore it. The aperture base address and the number of pages are build-time parameters.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, the configuration register reads 0, the entry-address register reads 0, and every table entry is invalid, so any lookup faults even once translation is enabled.
- R2: The register port decodes byte offset 0x0 as the configuration register (bit 0 is the enable, other bits read 0), 0x4 as the 32-bit entry-address register (read back unchanged) and 0x8 as the entry-data register. Writes to any other offset are ignored, and reads from any other offset return 0.
- R3: `reg_ready` is always high. A read accepted in one cycle raises `reg_rvalid` with its data in the next cycle, for exactly one cycle. A write never raises `reg_rvalid`.
- R4: A write to offset 0x8 stores bit 31 as the valid flag and bits 30:12 as the physical page number, into the entry covering the page that holds the entry-address value. Bits 11:0 are discarded, so a read back returns them as 0.
- R5: A read of offset 0x8 returns the entry covering the current entry-address value. Stepping that address by 4096 visits consecutive entries.
- R6: When the entry address lies below the aperture base, or at or above base + pages × 4096, a write to offset 0x8 changes no entry and a read of offset 0x8 returns 0.
- R7: When translation is enabled, the address lies in the aperture and its entry is valid, `lk_fault` is 0 and `lk_pa` equals {1'b0, page number, `lk_addr[11:0]`}.
- R8: When translation is disabled, every lookup faults. On every fault `lk_pa` is 0.
- R9: A lookup address below the base or at or above base + pages × 4096 faults, including the first address past the last page.
- R10: A lookup whose entry has bit 31 clear faults. Writing an all-zero word unmaps a page.
- R11: The lookup path is combinational from the table. A lookup in the same cycle as an entry write sees the old entry, and a lookup in the following cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register request present |
| reg_ready | output | 1 | Register request accepted (always 1) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_offs | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read |
| reg_rdata | output | 32 | Read data |
| lk_addr | input | 32 | Client device address |
| lk_pa | output | 32 | Translated physical address, 0 on fault |
| lk_fault | output | 1 | Lookup fault |

## Verification
The assertions take for granted that the register-port fields and the lookup address are never unknown while reset is released. They also assume that a read response is judged only in the cycle directly after its request. The checks on the lookup port assume that `lk_addr` does not change between the sampling edge and the evaluation.

The stimulus follows these assumptions. It drives every input at the falling edge and holds each register request for exactly one rising edge. It sets the lookup address once and then waits for it to settle before it compares any lookup output.

// File: rtl/apx_pkg.sv
package apx_pkg;

  localparam int PG_SHIFT = 12;
  localparam int PPN_W    = 31 - PG_SHIFT;
  localparam int OFFS_W   = 4;

  localparam logic [OFFS_W-1:0] OFF_CFG   = 4'h0;
  localparam logic [OFFS_W-1:0] OFF_EADDR = 4'h4;
  localparam logic [OFFS_W-1:0] OFF_EDATA = 4'h8;

  typedef struct packed {
    logic             valid;
    logic [PPN_W-1:0] ppn;
  } pte_t;

  function automatic pte_t word_to_pte(input logic [31:0] w);
    pte_t p;
    p.valid = w[31];
    p.ppn   = w[30:PG_SHIFT];
    return p;
  endfunction

  function automatic logic [31:0] pte_to_word(input pte_t p);
    return {p.valid, p.ppn, {PG_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/apx_range.sv
module apx_range
  import apx_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h0800_0000,
  parameter int          PAGES = 1024,
  localparam int         IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic [31:0]      addr,
  output logic             in_ap,
  output logic [IDX_W-1:0] idx
);

  localparam logic [32:0] SPAN = 33'(PAGES) << PG_SHIFT;

  logic [32:0] off;

  always_comb begin
    off   = {1'b0, addr} - {1'b0, BASE};
    in_ap = (addr >= BASE) && (off < SPAN);
    idx   = off[PG_SHIFT +: IDX_W];
  end

endmodule

// File: rtl/apx_table.sv
module apx_table
  import apx_pkg::*;
#(
  parameter int  PAGES = 1024,
  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  pte_t             wpte,
  input  logic [IDX_W-1:0] ridx_a,
  output pte_t             rpte_a,
  input  logic [IDX_W-1:0] ridx_b,
  output pte_t             rpte_b
);

  pte_t             ents [PAGES];
  logic [PAGES-1:0] ent_ce;

  genvar g;
  generate
    for (g = 0; g < PAGES; g++) begin : g_ent
      always_comb ent_ce[g] = we && (widx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ents[g] <= '0;
        else if (ent_ce[g]) ents[g] <= wpte;
      end
    end
  endgenerate

  assign rpte_a = ents[ridx_a];
  assign rpte_b = ents[ridx_b];

endmodule

// File: rtl/apx_regport.sv
module apx_regport
  import apx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [OFFS_W-1:0] reg_offs,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  output logic              xlate_en,
  output logic [31:0]       eaddr,
  input  logic              ea_in,
  input  pte_t              ea_pte,
  output logic              tbl_we,
  output pte_t              tbl_wpte
);

  logic        en_q, en_d;
  logic [31:0] ea_q, ea_d;
  logic [31:0] rd_q, rd_d;
  logic        rv_q, rv_d;
  logic        acc;

  assign reg_ready = 1'b1;
  assign acc       = reg_valid;

  always_comb begin
    en_d     = en_q;
    ea_d     = ea_q;
    rd_d     = rd_q;
    rv_d     = 1'b0;
    tbl_we   = 1'b0;
    tbl_wpte = word_to_pte(reg_wdata);
    if (acc) begin
      if (reg_write) begin
        unique case (reg_offs)
          OFF_CFG:   en_d   = reg_wdata[0];
          OFF_EADDR: ea_d   = reg_wdata;
          OFF_EDATA: tbl_we = ea_in;
          default:   ;
        endcase
      end else begin
        rv_d = 1'b1;
        unique case (reg_offs)
          OFF_CFG:   rd_d = {31'b0, en_q};
          OFF_EADDR: rd_d = ea_q;
          OFF_EDATA: rd_d = ea_in ? pte_to_word(ea_pte) : 32'b0;
          default:   rd_d = 32'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ea_q <= '0;
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      en_q <= en_d;
      ea_q <= ea_d;
      rd_q <= rd_d;
      rv_q <= rv_d;
    end
  end

  assign xlate_en   = en_q;
  assign eaddr      = ea_q;
  assign reg_rdata  = rd_q;
  assign reg_rvalid = rv_q;

endmodule

// File: rtl/apx_lookup.sv
module apx_lookup
  import apx_pkg::*;
(
  input  logic                xlate_en,
  input  logic                in_ap,
  input  pte_t                pte,
  input  logic [PG_SHIFT-1:0] pg_off,
  output logic [31:0]         pa,
  output logic                fault
);

  logic hit;

  always_comb begin
    hit   = xlate_en && in_ap && pte.valid;
    fault = !hit;
    pa    = hit ? {1'b0, pte.ppn, pg_off} : 32'b0;
  end

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import apx_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h0800_0000,
  parameter int          PAGES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  output logic        reg_ready,
  input  logic        reg_write,
  input  logic [3:0]  reg_offs,
  input  logic [31:0] reg_wdata,
  output logic        reg_rvalid,
  output logic [31:0] reg_rdata,
  input  logic [31:0] lk_addr,
  output logic [31:0] lk_pa,
  output logic        lk_fault
);

  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic             xlate_en;
  logic [31:0]      eaddr;
  logic             ea_in, lk_in;
  logic [IDX_W-1:0] ea_idx, lk_idx;
  pte_t             ea_pte, lk_pte, wpte;
  logic             tbl_we;

  apx_range #(.BASE(BASE), .PAGES(PAGES)) u_ea_rng (
    .addr(eaddr), .in_ap(ea_in), .idx(ea_idx)
  );

  apx_range #(.BASE(BASE), .PAGES(PAGES)) u_lk_rng (
    .addr(lk_addr), .in_ap(lk_in), .idx(lk_idx)
  );

  apx_regport u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_offs(reg_offs), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .xlate_en(xlate_en), .eaddr(eaddr),
    .ea_in(ea_in), .ea_pte(ea_pte),
    .tbl_we(tbl_we), .tbl_wpte(wpte)
  );

  apx_table #(.PAGES(PAGES)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .widx(ea_idx), .wpte(wpte),
    .ridx_a(ea_idx), .rpte_a(ea_pte),
    .ridx_b(lk_idx), .rpte_b(lk_pte)
  );

  apx_lookup u_lk (
    .xlate_en(xlate_en), .in_ap(lk_in), .pte(lk_pte),
    .pg_off(lk_addr[PG_SHIFT-1:0]),
    .pa(lk_pa), .fault(lk_fault)
  );

endmodule

// File: rtl/apx_checker.sv
module apx_checker #(
  parameter logic [31:0] BASE  = 32'h0800_0000,
  parameter int          PAGES = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_valid,
  input logic        reg_write,
  input logic [3:0]  reg_offs,
  input logic        wr_bit0,
  input logic        reg_rvalid,
  input logic [31:0] lk_addr,
  input logic [31:0] lk_pa,
  input logic        lk_fault
);

  localparam logic [32:0] TOP = {1'b0, BASE} + (33'(PAGES) << 12);

  logic outside;
  assign outside = ({1'b0, lk_addr} < {1'b0, BASE}) || ({1'b0, lk_addr} >= TOP);

  assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> reg_rvalid);

  assert_rvalid_only_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_valid && !reg_write));

  assert_fault_zero_pa_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_pa == 32'b0));

  assert_disable_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_offs == 4'h0 && !wr_bit0) |=> lk_fault);

  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fault |-> (lk_pa[11:0] == lk_addr[11:0] && !lk_pa[31]));

  assert_outside_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> lk_fault);

endmodule

bind aperture_xlate apx_checker #(.BASE(BASE), .PAGES(PAGES)) u_apx_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_offs(reg_offs), .wr_bit0(reg_wdata[0]), .reg_rvalid(reg_rvalid),
  .lk_addr(lk_addr), .lk_pa(lk_pa), .lk_fault(lk_fault)
);

// File: tb/aperture_xlate_bench.sv
`timescale 1ns/1ps
module aperture_xlate_bench;

  localparam logic [31:0] BASE = 32'h0800_0000;
  localparam int          PAGES = 1024;
  localparam logic [31:0] SPAN = 32'(PAGES) * 32'd4096;
  localparam logic [31:0] PG   = 32'd4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_ready, reg_write, reg_rvalid, lk_fault;
  logic [3:0]  reg_offs;
  logic [31:0] reg_wdata, reg_rdata, lk_addr, lk_pa;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  aperture_xlate #(.BASE(BASE), .PAGES(PAGES)) u_aperture_xlate (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_offs(reg_offs), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .lk_addr(lk_addr), .lk_pa(lk_pa), .lk_fault(lk_fault)
  );

  // monitor: pops expected read data when a response appears
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected read response %h, expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read data %h, expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic reg_wr(input logic [3:0] offs, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_offs = offs; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] offs, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_offs = offs;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic chk_lk(input logic [31:0] a, input logic ef, input logic [31:0] epa,
                        input string t);
    lk_addr = a;
    #1;
    n_chk++;
    if (lk_fault !== ef || lk_pa !== epa) begin
      n_fail++;
      $display("FAIL %s: addr %h fault %b pa %h, expected fault %b pa %h",
               t, a, lk_fault, lk_pa, ef, epa);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_offs = '0;
    reg_wdata = '0; lk_addr = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(4'h0, 32'h0, "R1 cfg");
    reg_rd(4'h4, 32'h0, "R1 eaddr");
    n_chk++;
    if (reg_ready !== 1'b1) begin
      n_fail++; $display("FAIL R3: ready %b, expected 1", reg_ready);
    end
    reg_wr(4'h4, BASE + 7*PG);
    reg_rd(4'h8, 32'h0, "R1 entry cleared");
    reg_wr(4'h0, 32'h1);
    chk_lk(BASE + 7*PG + 32'h44, 1'b1, 32'h0, "R1 invalid after reset");
    reg_wr(4'h0, 32'h0);

    // R2 / R4 entry address and data
    reg_wr(4'h4, BASE + 5*PG + 32'h123);
    reg_rd(4'h4, BASE + 5*PG + 32'h123, "R2 eaddr readback");
    reg_wr(4'h8, 32'h8001_2FFF);
    reg_rd(4'h8, 32'h8001_2000, "R4 low bits dropped");
    chk_lk(BASE + 5*PG + 32'hABC, 1'b1, 32'h0, "R8 disabled");
    reg_wr(4'h0, 32'hFFFF_FFFF);
    reg_rd(4'h0, 32'h1, "R2 cfg bit0 only");
    chk_lk(BASE + 5*PG + 32'hABC, 1'b0, 32'h0001_2ABC, "R7 translate");

    // R5 walk entries 0..3
    for (int i = 0; i < 4; i++) begin
      reg_wr(4'h4, BASE + 32'(i)*PG);
      reg_wr(4'h8, 32'h8000_0000 | ((32'h100 + 32'(i)) << 12));
    end
    for (int i = 0; i < 4; i++) begin
      reg_wr(4'h4, BASE + 32'(i)*PG);
      reg_rd(4'h8, 32'h8000_0000 | ((32'h100 + 32'(i)) << 12), "R5 walk");
    end
    // last page
    reg_wr(4'h4, BASE + SPAN - PG);
    reg_wr(4'h8, 32'hFFFF_F000);
    chk_lk(BASE + SPAN - 1, 1'b0, 32'h7FFF_FFFF, "R7 last page");

    // R9 outside aperture
    chk_lk(BASE - 1, 1'b1, 32'h0, "R9 below base");
    chk_lk(BASE + SPAN, 1'b1, 32'h0, "R9 past end");

    // R6 out-of-aperture table access
    reg_wr(4'h4, BASE + SPAN);
    reg_wr(4'h8, 32'h8000_1000);
    reg_rd(4'h8, 32'h0, "R6 read outside");
    chk_lk(BASE + 32'h10, 1'b0, 32'h0010_0010, "R6 entry0 untouched");
    reg_wr(4'h4, BASE - PG);
    reg_wr(4'h8, 32'h8000_2000);
    chk_lk(BASE + SPAN - 1, 1'b0, 32'h7FFF_FFFF, "R6 last entry untouched");

    // R2 unknown offset
    reg_wr(4'hC, 32'h0);
    reg_rd(4'hC, 32'h0, "R2 unknown offset read");
    reg_rd(4'h0, 32'h1, "R2 unknown offset write ignored");

    // R10 unmap and invalid flag
    reg_wr(4'h4, BASE + 5*PG);
    reg_wr(4'h8, 32'h0);
    chk_lk(BASE + 5*PG + 32'h8, 1'b1, 32'h0, "R10 unmapped");
    reg_wr(4'h4, BASE + 1*PG);
    reg_wr(4'h8, 32'h0001_2000);
    chk_lk(BASE + 1*PG, 1'b1, 32'h0, "R10 bit31 clear");

    // R11 same-cycle update
    reg_wr(4'h4, BASE + 2*PG);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_offs = 4'h8; reg_wdata = 32'h8077_7000;
    chk_lk(BASE + 2*PG + 32'h10, 1'b0, 32'h0010_2010, "R11 old entry same cycle");
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    chk_lk(BASE + 2*PG + 32'h10, 1'b0, 32'h0077_7010, "R11 new entry next cycle");

    // R8 disable again
    reg_wr(4'h0, 32'h0);
    chk_lk(BASE + 2*PG, 1'b1, 32'h0, "R8 disabled again");
    reg_rd(4'h0, 32'h0, "R8 cfg cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R3: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule